// File: doc/BRIEF.md
# Remote Terminal BUSY Flag Controller

This block owns the BUSY flag of a remote terminal. The flag sits in two 16-bit status words: the last-status word, which the terminal reports back on the bus, and the basic-status word, which the host maintains. Three events can raise BUSY:

- the master reset, which is the block's synchronous active-low reset `rst_n`;
- a software reset strobe;
- a valid mode command carrying the reset-remote-terminal code (8).

A single option bit in a host configuration register selects which of these events count. When the option bit is 0, all three raise BUSY. When it is 1, only the master reset does.

The host clears BUSY in the last-status word by writing 1 to a self-clearing control bit in the configuration register. That write leaves every other bit of the last-status word alone. BUSY in the basic-status word is cleared only when the host writes that word directly. The terminal's transmit path reloads the non-BUSY bits of the last-status word through a load port. The host reads all three registers through a combinational read port.

Register map (2-bit address):

| Address | Register | Host access |
|---|---|---|
| 0 | Configuration | read and write |
| 1 | Last-status | read only |
| 2 | Basic-status | read and write |
| 3 | (none) | reads as zero |

Configuration register fields:

| Bit | Field | Behaviour |
|---|---|---|
| 0 | MR_ONLY | option bit; 1 means only the master reset raises BUSY |
| 1 | CLR_LAST_BUSY | write 1 clears last-status BUSY; always reads 0 |
| 15:2 | spare | plain storage |

BUSY is bit 3 of both status words.

Top module: `rt_busy_ctrl`

## Requirements
- R1: While `rst_n` is low, the block is initialised on the next clock edge: the configuration register becomes 0x0000 (MR_ONLY becomes 0), and both status words become 0x0008 (BUSY set, all other bits 0). Both BUSY outputs are therefore 1 after the edge.
- R2: With MR_ONLY=0, a one-cycle `sw_rst_i` pulse sets BUSY in both status words at the next clock edge.
- R3: With MR_ONLY=0, a cycle with `mc_valid_i`=1 and `mc_code_i`=8 sets BUSY in both words at the next edge. Other codes, and code 8 with `mc_valid_i`=0, leave both BUSY bits unchanged.
- R4: With MR_ONLY=1, `sw_rst_i` and a valid mode code 8 leave both BUSY bits unchanged.
- R5: A host write to address 0 with data bit 1 set clears last-status BUSY at the next edge. All other last-status bits and basic-status BUSY are unchanged.
- R6: Reading address 0 always returns 0 in bit 1. Bit 0 and bits 15:2 read back as last written.
- R7: A configuration write with data bit 1 clear does not change last-status BUSY.
- R8: If a setting event (R2/R3) and a last-status clear (R5) occur in the same cycle, BUSY ends up 1.
- R9: A host write to address 2 replaces the whole basic-status word, BUSY included, at the next edge. This is the only way basic-status BUSY returns to 0.
- R10: `ls_load_i` replaces last-status bits other than bit 3 with `ls_word_i`, and BUSY keeps its value. Host writes to address 1 have no effect.
- R11: Whether `sw_rst_i` or mode code 8 sets BUSY is decided by the MR_ONLY value held before any configuration write in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master reset, synchronous, active low |
| sw_rst_i | input | 1 | Software reset strobe |
| mc_valid_i | input | 1 | Mode command valid strobe |
| mc_code_i | input | 5 | Mode code of the command |
| ls_load_i | input | 1 | Load strobe for the last-status word |
| ls_word_i | input | 16 | Last-status word from the terminal |
| wr_en_i | input | 1 | Host write enable |
| wr_addr_i | input | 2 | Host write address |
| wr_data_i | input | 16 | Host write data |
| rd_addr_i | input | 2 | Host read address |
| rd_data_o | output | 16 | Host read data (combinational) |
| busy_last_o | output | 1 | BUSY bit of the last-status word |
| busy_basic_o | output | 1 | BUSY bit of the basic-status word |

## Verification
Every state change is registered once. A strobe or write driven in one cycle is therefore visible on the BUSY outputs and the read port just after the next rising edge, while read data follows the read address with no delay. The bench drives each stimulus on a falling edge and holds it for exactly one rising edge. It removes the stimulus on the following falling edge and samples outputs and read data there, half a period after the edge that updated them. The same-cycle cases (set against clear, option change against reset strobe) place both stimuli in the same driven cycle so that a single edge resolves them.

// File: rtl/rbc_pkg.sv
// Package: shared register map and field positions for the BUSY controller.
// Assumes a 2-bit host address space with four register slots.
package rbc_pkg;

    typedef enum logic [1:0] {
        REG_CFG   = 2'd0,
        REG_LAST  = 2'd1,
        REG_BASIC = 2'd2,
        REG_NONE  = 2'd3
    } rbc_reg_e;

    localparam int CFG_MR_ONLY_BIT  = 0;
    localparam int CFG_CLR_BUSY_BIT = 1;

endpackage

// File: rtl/rbc_set_arbiter.sv
// Module: rbc_set_arbiter
// Decides whether a non-master reset event should set BUSY this cycle.
// Assumes mr_only is the registered option value (not the same-cycle write).
module rbc_set_arbiter #(
    parameter int MC_W     = 5,
    parameter int MC_RESET = 8
) (
    input  logic            sw_rst,
    input  logic            mc_valid,
    input  logic [MC_W-1:0] mc_code,
    input  logic            mr_only,
    output logic            set_busy
);

    localparam logic [MC_W-1:0] RESET_CODE = MC_W'(MC_RESET);

    logic mc_reset_hit;

    // Decode a valid reset-remote-terminal mode command.
    always_comb mc_reset_hit = mc_valid && (mc_code == RESET_CODE);

    // Gate soft sources with the option bit.
    always_comb set_busy = !mr_only && (sw_rst || mc_reset_hit);

endmodule

// File: rtl/rbc_cfg_reg.sv
// Module: rbc_cfg_reg
// Holds the configuration register and decodes host writes into strobes.
// Assumes synchronous active-low master reset; the clear-busy bit is never stored.
module rbc_cfg_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] cfg_word,
    output logic              mr_only,
    output logic              clr_last_busy,
    output logic              wr_basic
);
    import rbc_pkg::*;

    localparam logic [DATA_W-1:0] STORE_MASK = ~(DATA_W'(1) << CFG_CLR_BUSY_BIT);

    logic [DATA_W-1:0] cfg_q;
    logic              wr_cfg;

    // Address decode of host writes.
    always_comb begin
        wr_cfg   = wr_en && (rbc_reg_e'(wr_addr) == REG_CFG);
        wr_basic = wr_en && (rbc_reg_e'(wr_addr) == REG_BASIC);
    end

    // Self-clearing control strobe, never held in storage.
    always_comb clr_last_busy = wr_cfg && wr_data[CFG_CLR_BUSY_BIT];

    // Configuration storage, cleared on master reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (wr_cfg) cfg_q <= wr_data & STORE_MASK;
    end

    // Outputs derived from storage.
    always_comb begin
        cfg_word = cfg_q;
        mr_only  = cfg_q[CFG_MR_ONLY_BIT];
    end

endmodule

// File: rtl/rbc_status_reg.sv
// Module: rbc_status_reg
// One status word with a BUSY bit; set beats clear beats word load.
// KEEP_BUSY_ON_LOAD=1 makes a load leave BUSY untouched.
module rbc_status_reg #(
    parameter int DATA_W            = 16,
    parameter int BUSY_POS          = 3,
    parameter bit KEEP_BUSY_ON_LOAD = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_word,
    input  logic              clr_busy,
    input  logic              set_busy,
    output logic [DATA_W-1:0] word
);

    localparam logic [DATA_W-1:0] BUSY_MASK = DATA_W'(1) << BUSY_POS;

    logic [DATA_W-1:0] word_q;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] word_d;

    // Choose how a load treats the BUSY bit.
    generate
        if (KEEP_BUSY_ON_LOAD) begin : g_keep
            always_comb merged = (load_word & ~BUSY_MASK) | (word_q & BUSY_MASK);
        end else begin : g_full
            always_comb merged = load_word;
        end
    endgenerate

    // Next-state with set having highest priority.
    always_comb begin
        word_d = load ? merged : word_q;
        if (clr_busy) word_d[BUSY_POS] = 1'b0;
        if (set_busy) word_d[BUSY_POS] = 1'b1;
    end

    // Status storage, BUSY raised on master reset.
    always_ff @(posedge clk) begin
        if (!rst_n) word_q <= BUSY_MASK;
        else        word_q <= word_d;
    end

    // Expose the stored word.
    always_comb word = word_q;

endmodule

// File: rtl/rt_busy_ctrl.sv
// Module: rt_busy_ctrl (top)
// BUSY flag control for a remote terminal's last-status and basic-status words.
// Assumes rst_n is the master reset pin, synchronous and active low.
module rt_busy_ctrl #(
    parameter int DATA_W   = 16,
    parameter int BUSY_POS = 3,
    parameter int MC_W     = 5,
    parameter int MC_RESET = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst_i,
    input  logic              mc_valid_i,
    input  logic [MC_W-1:0]   mc_code_i,
    input  logic              ls_load_i,
    input  logic [DATA_W-1:0] ls_word_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [1:0]        rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              busy_last_o,
    output logic              busy_basic_o
);
    import rbc_pkg::*;

    logic [DATA_W-1:0] cfg_word;
    logic [DATA_W-1:0] last_word;
    logic [DATA_W-1:0] basic_word;
    logic              mr_only;
    logic              clr_last_busy;
    logic              wr_basic;
    logic              set_busy;

    rbc_cfg_reg #(.DATA_W(DATA_W)) u_cfg (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en_i),
        .wr_addr       (wr_addr_i),
        .wr_data       (wr_data_i),
        .cfg_word      (cfg_word),
        .mr_only       (mr_only),
        .clr_last_busy (clr_last_busy),
        .wr_basic      (wr_basic)
    );

    rbc_set_arbiter #(.MC_W(MC_W), .MC_RESET(MC_RESET)) u_arb (
        .sw_rst   (sw_rst_i),
        .mc_valid (mc_valid_i),
        .mc_code  (mc_code_i),
        .mr_only  (mr_only),
        .set_busy (set_busy)
    );

    rbc_status_reg #(.DATA_W(DATA_W), .BUSY_POS(BUSY_POS), .KEEP_BUSY_ON_LOAD(1'b1)) u_last (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ls_load_i),
        .load_word (ls_word_i),
        .clr_busy  (clr_last_busy),
        .set_busy  (set_busy),
        .word      (last_word)
    );

    rbc_status_reg #(.DATA_W(DATA_W), .BUSY_POS(BUSY_POS), .KEEP_BUSY_ON_LOAD(1'b0)) u_basic (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wr_basic),
        .load_word (wr_data_i),
        .clr_busy  (1'b0),
        .set_busy  (set_busy),
        .word      (basic_word)
    );

    // Host read multiplexer.
    always_comb begin
        unique case (rbc_reg_e'(rd_addr_i))
            REG_CFG:   rd_data_o = cfg_word;
            REG_LAST:  rd_data_o = last_word;
            REG_BASIC: rd_data_o = basic_word;
            default:   rd_data_o = '0;
        endcase
    end

    // BUSY outputs.
    always_comb begin
        busy_last_o  = last_word[BUSY_POS];
        busy_basic_o = basic_word[BUSY_POS];
    end

endmodule

// File: rtl/rbc_checker.sv
// Module: rbc_checker
// Temporal properties of rt_busy_ctrl, attached by bind.
module rbc_checker #(
    parameter int DATA_W   = 16,
    parameter int BUSY_POS = 3,
    parameter int MC_W     = 5,
    parameter int MC_RESET = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_rst,
    input logic              mc_valid,
    input logic [MC_W-1:0]   mc_code,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic              wr_clr_bit,
    input logic              ls_load,
    input logic [1:0]        rd_addr,
    input logic              rd_clr_bit,
    input logic              mr_only,
    input logic [DATA_W-1:0] last_word,
    input logic              busy_last,
    input logic              busy_basic
);
    localparam logic [DATA_W-1:0] OTHER_MASK = ~(DATA_W'(1) << BUSY_POS);

    logic mc8;
    logic clr;
    logic basic_wr;
    always_comb begin
        mc8      = mc_valid && (mc_code == MC_W'(MC_RESET));
        clr      = wr_en && (wr_addr == 2'd0) && wr_clr_bit;
        basic_wr = wr_en && (wr_addr == 2'd2);
    end

    assert_sw_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mr_only && sw_rst) |=> (busy_last && busy_basic));

    assert_mc8_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mr_only && mc8) |=> (busy_last && busy_basic));

    assert_mronly_basic_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mr_only && (sw_rst || mc8) && !basic_wr) |=> $stable(busy_basic));

    assert_mronly_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mr_only && (sw_rst || mc8) && !clr) |=> $stable(busy_last));

    assert_clr_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !sw_rst && !mc8) |=> !busy_last);

    assert_clr_keeps_other_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ls_load) |=> $stable(last_word & OTHER_MASK));

    assert_clr_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 2'd0) |-> !rd_clr_bit);

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mr_only && sw_rst && clr) |=> busy_last);

    assert_basic_only_host_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!basic_wr && busy_basic) |=> busy_basic);

endmodule

bind rt_busy_ctrl rbc_checker #(
    .DATA_W(DATA_W), .BUSY_POS(BUSY_POS), .MC_W(MC_W), .MC_RESET(MC_RESET)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_rst     (sw_rst_i),
    .mc_valid   (mc_valid_i),
    .mc_code    (mc_code_i),
    .wr_en      (wr_en_i),
    .wr_addr    (wr_addr_i),
    .wr_clr_bit (wr_data_i[1]),
    .ls_load    (ls_load_i),
    .rd_addr    (rd_addr_i),
    .rd_clr_bit (rd_data_o[1]),
    .mr_only    (mr_only),
    .last_word  (last_word),
    .busy_last  (busy_last_o),
    .busy_basic (busy_basic_o)
);

// File: tb/sim_rt_busy_ctrl.sv
// Directed bench for rt_busy_ctrl: one task per scenario.
module sim_rt_busy_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_rst_i = 1'b0;
    logic        mc_valid_i = 1'b0;
    logic [4:0]  mc_code_i = '0;
    logic        ls_load_i = 1'b0;
    logic [15:0] ls_word_i = '0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_addr_i = '0;
    logic [15:0] wr_data_i = '0;
    logic [1:0]  rd_addr_i = '0;
    logic [15:0] rd_data_o;
    logic        busy_last_o;
    logic        busy_basic_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rt_busy_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .sw_rst_i(sw_rst_i), .mc_valid_i(mc_valid_i),
        .mc_code_i(mc_code_i), .ls_load_i(ls_load_i), .ls_word_i(ls_word_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
        .busy_last_o(busy_last_o), .busy_basic_o(busy_basic_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        sw_rst_i = 0; mc_valid_i = 0; mc_code_i = '0; ls_load_i = 0;
        wr_en_i = 0; wr_addr_i = '0; wr_data_i = '0;
    endtask

    // One cycle: stimulus already driven at this falling edge; move to next one and clear.
    task automatic cycle();
        @(negedge clk);
        idle();
    endtask

    task automatic hwrite(input logic [1:0] a, input logic [15:0] d);
        wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
        cycle();
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        rd_addr_i = a; #1; d = rd_data_o;
    endtask

    task automatic clear_both();
        hwrite(2'd2, 16'h0000);
        hwrite(2'd0, 16'h0002);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        rst_n = 0; idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        check("R1 busy_last", {15'd0, busy_last_o}, 16'd1);
        check("R1 busy_basic", {15'd0, busy_basic_o}, 16'd1);
        rd(2'd0, d); check("R1 cfg", d, 16'h0000);
        rd(2'd1, d); check("R1 last", d, 16'h0008);
        rd(2'd2, d); check("R1 basic", d, 16'h0008);
    endtask

    task automatic t_load_and_clear();
        logic [15:0] d;
        ls_load_i = 1; ls_word_i = 16'hF0F0; cycle();
        rd(2'd1, d); check("R10 load keeps busy", d, 16'hF0F8);
        hwrite(2'd0, 16'h0002);
        check("R5 last busy cleared", {15'd0, busy_last_o}, 16'd0);
        rd(2'd1, d); check("R5 other bits kept", d, 16'hF0F0);
        check("R5 basic busy kept", {15'd0, busy_basic_o}, 16'd1);
        rd(2'd0, d); check("R6 clear bit reads 0", d, 16'h0000);
        ls_load_i = 1; ls_word_i = 16'h000F; cycle();
        rd(2'd1, d); check("R10 load keeps busy 0", d, 16'h0007);
    endtask

    task automatic t_sw_and_write0();
        logic [15:0] d;
        sw_rst_i = 1; cycle();
        check("R2 sw sets last", {15'd0, busy_last_o}, 16'd1);
        check("R2 sw sets basic", {15'd0, busy_basic_o}, 16'd1);
        hwrite(2'd0, 16'h0000);
        check("R7 write0 no effect", {15'd0, busy_last_o}, 16'd1);
        hwrite(2'd1, 16'hFFF0);
        rd(2'd1, d); check("R10 host write to last ignored", d, 16'h000F);
    endtask

    task automatic t_basic();
        logic [15:0] d;
        hwrite(2'd2, 16'h1234);
        check("R9 basic busy cleared", {15'd0, busy_basic_o}, 16'd0);
        rd(2'd2, d); check("R9 basic readback", d, 16'h1234);
        check("R9 last busy untouched", {15'd0, busy_last_o}, 16'd1);
        hwrite(2'd2, 16'h0008);
        check("R9 basic busy set by write", {15'd0, busy_basic_o}, 16'd1);
        rd(2'd3, d); check("R9 unused address reads 0", d, 16'h0000);
    endtask

    task automatic t_mode_code();
        clear_both();
        mc_valid_i = 1; mc_code_i = 5'd7; cycle();
        check("R3 code7 no set", {14'd0, busy_last_o, busy_basic_o}, 16'd0);
        mc_valid_i = 0; mc_code_i = 5'd8; cycle();
        check("R3 invalid code8 no set", {14'd0, busy_last_o, busy_basic_o}, 16'd0);
        mc_valid_i = 1; mc_code_i = 5'd8; cycle();
        check("R3 code8 sets both", {14'd0, busy_last_o, busy_basic_o}, 16'd3);
    endtask

    task automatic t_mr_only();
        logic [15:0] d;
        hwrite(2'd2, 16'h0000);
        hwrite(2'd0, 16'hABC3);
        rd(2'd0, d); check("R6 cfg readback", d, 16'hABC1);
        sw_rst_i = 1; cycle();
        check("R4 sw ignored", {14'd0, busy_last_o, busy_basic_o}, 16'd0);
        mc_valid_i = 1; mc_code_i = 5'd8; cycle();
        check("R4 code8 ignored", {14'd0, busy_last_o, busy_basic_o}, 16'd0);
    endtask

    task automatic t_order();
        wr_en_i = 1; wr_addr_i = 2'd0; wr_data_i = 16'h0000; sw_rst_i = 1; cycle();
        check("R11 old option 1 blocks", {14'd0, busy_last_o, busy_basic_o}, 16'd0);
        wr_en_i = 1; wr_addr_i = 2'd0; wr_data_i = 16'h0001; sw_rst_i = 1; cycle();
        check("R11 old option 0 sets", {14'd0, busy_last_o, busy_basic_o}, 16'd3);
    endtask

    task automatic t_set_wins();
        hwrite(2'd0, 16'h0000);
        clear_both();
        wr_en_i = 1; wr_addr_i = 2'd0; wr_data_i = 16'h0002; sw_rst_i = 1; cycle();
        check("R8 set beats clear", {15'd0, busy_last_o}, 16'd1);
    endtask

    task automatic t_master_reset();
        logic [15:0] d;
        hwrite(2'd0, 16'h0003);
        hwrite(2'd2, 16'h0000);
        rst_n = 0; @(negedge clk); rst_n = 1;
        check("R1 master reset sets both", {14'd0, busy_last_o, busy_basic_o}, 16'd3);
        rd(2'd0, d); check("R1 master reset clears cfg", d, 16'h0000);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_load_and_clear();
        t_sw_and_write0();
        t_basic();
        t_mode_code();
        t_mr_only();
        t_order();
        t_set_wins();
        t_master_reset();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule